// File: doc/BRIEF.md
# Indirect Packet-Buffer Access Port

This block lets a host processor reach a 16 KB packet buffer SRAM through two kinds of bus cycle. An index cycle picks one register. Data cycles then act on that register until the next index cycle, so a stream of data cycles repeats one buffer command with no further index writes.

The block keeps two byte pointers: one for reading the receive region (0C00h to 3FFFh) and one for writing the transmit region. Each command register moves one byte in 8-bit mode or one little-endian word in 16-bit mode. Depending on the command, the pointer either advances or stays where it is.

One of the read commands also captures the fetched word in a one-word prefetch buffer, so a later read of the same word completes in one cycle instead of three. Both pointers and a 16-bit transmit length are byte-wide read/write registers. A level input presets the receive pointer's high byte to the start of the receive region.

Top module: `sram_cmd_port`

## Requirements
- R1: A request with `hst_index`=1 and `hst_write`=1 stores `hst_wdata[7:0]` as the selected register index. Each later data cycle (`hst_index`=0) acts on that index, so repeated data cycles repeat the same command. After reset, `hst_ack` is low and both pointers and the transmit length read as zero. Every request is acknowledged by a one-cycle `hst_ack` pulse.
- R2: A data read of index F1h returns the receive data at the read pointer and leaves the pointer unchanged. In 8-bit mode the data is the byte `ptr[0]` selects (even address on bits 7:0, odd address on bits 15:8 of the SRAM word), zero-extended. In 16-bit mode it is the whole word and `ptr[0]` is ignored. A read served from the SRAM acknowledges three cycles after the request edge, and `sram_re` is a single-cycle strobe.
- R3: A data read of index F2h returns the same data as F1h would, then advances the read pointer by 1 in 8-bit mode or by 2 in 16-bit mode.
- R4: A data read of index F0h behaves like F1h and also loads the fetched word, tagged with its word address, into the prefetch buffer. Any read command whose word address matches a valid buffer entry acknowledges one cycle after the request. F1h and F2h never load the buffer.
- R5: A write to either read-pointer byte invalidates the prefetch buffer, even when the value written does not change the pointer.
- R6: The read pointer wraps to 0C00h when an advance would pass 3FFFh.
- R7: A data write of index F6h stores data at the write pointer and leaves the pointer unchanged. Index F8h stores and then advances the pointer by 1 or 2 (modulo 16 K). In 8-bit mode `hst_wdata[7:0]` goes to the lane `ptr[0]` selects. In 16-bit mode bits 7:0 go to the even byte and bits 15:8 to the odd byte.
- R8: Read pointer low/high bytes are at F4h/F5h, write pointer low/high at FAh/FBh, transmit length low/high at FCh/FDh. All are read/write through data cycles. Pointer bits above bit 13 read as zero.
- R9: While `rx_preset` is high, the read pointer's high byte is forced to 0Ch on every clock, the low byte is kept, and the prefetch buffer is invalidated.
- R10: A buffer write to the word held in the prefetch buffer invalidates the buffer.
- R11: A data write to an index that is not writable is ignored. A data read of an index that is not a register returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus16 | input | 1 | 1 selects 16-bit mode, 0 selects 8-bit mode |
| rx_preset | input | 1 | Level preset of the read pointer high byte |
| hst_req | input | 1 | One-cycle host request strobe |
| hst_index | input | 1 | 1 for an index cycle, 0 for a data cycle |
| hst_write | input | 1 | 1 for a write, 0 for a read |
| hst_wdata | input | 16 | Host write data |
| hst_ack | output | 1 | One-cycle completion pulse |
| hst_rdata | output | 16 | Read data, valid with `hst_ack` |
| sram_re | output | 1 | SRAM read strobe |
| sram_we | output | 1 | SRAM write strobe |
| sram_be | output | 2 | SRAM byte lane enables |
| sram_addr | output | 13 | SRAM word address |
| sram_wdata | output | 16 | SRAM write data |
| sram_rdata | input | 16 | SRAM read data, one cycle after `sram_re` |

## Verification
The assertions check these behaviours on every cycle:
- the SRAM read strobe lasts one cycle and is followed two cycles later by the acknowledge;
- every write strobe enables at least one byte lane;
- invalidation by a pointer write, a preset or a snooped write always leaves the buffer empty;
- an advance always moves a pointer;
- a preset always leaves 0Ch in the high byte.

Only the bench's scenarios show the rest:
- the data values and byte-lane choice;
- the hit and miss latencies across command sequences;
- the wrap to 0C00h and the little-endian storage;
- the pointers left unchanged after F1h, F6h and ignored writes.

// File: rtl/sram_cmd_port_pkg.sv
package sram_cmd_port_pkg;
  localparam logic [7:0] IDX_RD_PF   = 8'hF0;
  localparam logic [7:0] IDX_RD_PEEK = 8'hF1;
  localparam logic [7:0] IDX_RD_INC  = 8'hF2;
  localparam logic [7:0] IDX_RDP_LO  = 8'hF4;
  localparam logic [7:0] IDX_RDP_HI  = 8'hF5;
  localparam logic [7:0] IDX_WR_STAY = 8'hF6;
  localparam logic [7:0] IDX_WR_INC  = 8'hF8;
  localparam logic [7:0] IDX_WRP_LO  = 8'hFA;
  localparam logic [7:0] IDX_WRP_HI  = 8'hFB;
  localparam logic [7:0] IDX_TXL_LO  = 8'hFC;
  localparam logic [7:0] IDX_TXL_HI  = 8'hFD;

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_LAND} port_st_t;
endpackage

// File: rtl/sram_cmd_ptr.sv
module sram_cmd_ptr #(
  parameter int ADDR_W = 14,
  parameter bit WRAP_EN = 1'b0,
  parameter logic [ADDR_W-1:0] WRAP_BASE = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_lo,
  input  logic              ld_hi,
  input  logic [7:0]        din,
  input  logic              adv,
  input  logic              step2,
  input  logic              preset,
  output logic [ADDR_W-1:0] q
);
  localparam int HI_W = ADDR_W - 8;

  logic [ADDR_W:0]   sum;
  logic [ADDR_W-1:0] adv_val;
  logic [ADDR_W-1:0] nx;

  assign sum     = {1'b0, q} + (ADDR_W+1)'(step2 ? 2 : 1);
  assign adv_val = (WRAP_EN && sum[ADDR_W]) ? WRAP_BASE : sum[ADDR_W-1:0];

  always_comb begin
    nx = q;
    if (ld_lo) nx[7:0] = din;
    if (ld_hi) nx[ADDR_W-1:8] = din[HI_W-1:0];
    if (adv)   nx = adv_val;
    if (preset) nx[ADDR_W-1:8] = WRAP_BASE[ADDR_W-1:8];
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nx;
  end

  assert_ptr_moves_R3: assert property (@(posedge clk) disable iff (rst)
    (adv && !ld_lo && !ld_hi && !preset) |=> (q != $past(q)));

  assert_preset_high_R9: assert property (@(posedge clk) disable iff (rst)
    preset |=> (q[ADDR_W-1:8] == WRAP_BASE[ADDR_W-1:8]));
endmodule

// File: rtl/sram_cmd_pfbuf.sv
module sram_cmd_pfbuf #(
  parameter int TAG_W = 13,
  parameter int DW = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [TAG_W-1:0] load_tag,
  input  logic [DW-1:0]    load_data,
  input  logic             inval,
  input  logic             snoop_en,
  input  logic [TAG_W-1:0] snoop_tag,
  input  logic [TAG_W-1:0] look_tag,
  output logic             hit,
  output logic [DW-1:0]    data
);
  logic             valid;
  logic [TAG_W-1:0] tag;
  logic             snoop_hit;

  assign snoop_hit = snoop_en && valid && (snoop_tag == tag);
  assign hit       = valid && (look_tag == tag);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      tag   <= '0;
      data  <= '0;
    end else if (inval || snoop_hit) begin
      valid <= 1'b0;
    end else if (load) begin
      valid <= 1'b1;
      tag   <= load_tag;
      data  <= load_data;
    end
  end

  assert_inval_empties_R5: assert property (@(posedge clk) disable iff (rst)
    inval |=> !valid);

  assert_load_fills_R4: assert property (@(posedge clk) disable iff (rst)
    (load && !inval && !snoop_en) |=> hit == (look_tag == $past(load_tag)));

  assert_snoop_empties_R10: assert property (@(posedge clk) disable iff (rst)
    snoop_hit |=> !valid);
endmodule

// File: rtl/sram_cmd_port.sv
module sram_cmd_port #(
  parameter int ADDR_W = 14,
  parameter logic [15:0] RX_BASE = 16'h0C00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus16,
  input  logic              rx_preset,
  input  logic              hst_req,
  input  logic              hst_index,
  input  logic              hst_write,
  input  logic [15:0]       hst_wdata,
  output logic              hst_ack,
  output logic [15:0]       hst_rdata,
  output logic              sram_re,
  output logic              sram_we,
  output logic [1:0]        sram_be,
  output logic [ADDR_W-2:0] sram_addr,
  output logic [15:0]       sram_wdata,
  input  logic [15:0]       sram_rdata
);
  import sram_cmd_port_pkg::*;

  localparam int WA_W = ADDR_W - 1;

  port_st_t          state;
  logic [7:0]        idx_q;
  logic [7:0]        pend_idx;
  logic [ADDR_W-1:0] pend_addr;
  logic [15:0]       txlen_q;
  logic [ADDR_W-1:0] rd_ptr, wr_ptr;
  logic [7:0]        reg_byte;

  logic go, data_cyc, reg_wr, is_rd_cmd, rd_acc, rd_hit, rd_miss, wr_acc;
  logic rd_adv, wr_adv, land, pf_hit, pf_load, pf_inval;
  logic [15:0] pf_data;

  function automatic logic [15:0] lane_pick(input logic [15:0] w, input logic wide,
                                            input logic odd);
    if (wide) return w;
    return {8'h00, odd ? w[15:8] : w[7:0]};
  endfunction

  assign go        = hst_req && (state == ST_IDLE);
  assign data_cyc  = go && !hst_index;
  assign reg_wr    = data_cyc && hst_write;
  assign is_rd_cmd = (idx_q == IDX_RD_PF) || (idx_q == IDX_RD_PEEK) || (idx_q == IDX_RD_INC);
  assign rd_acc    = data_cyc && !hst_write && is_rd_cmd;
  assign rd_hit    = rd_acc && pf_hit;
  assign rd_miss   = rd_acc && !pf_hit;
  assign wr_acc    = reg_wr && ((idx_q == IDX_WR_STAY) || (idx_q == IDX_WR_INC));
  assign land      = (state == ST_LAND);
  assign rd_adv    = (rd_hit && idx_q == IDX_RD_INC) || (land && pend_idx == IDX_RD_INC);
  assign wr_adv    = wr_acc && (idx_q == IDX_WR_INC);
  assign pf_load   = land && (pend_idx == IDX_RD_PF);
  assign pf_inval  = rx_preset || (reg_wr && (idx_q == IDX_RDP_LO || idx_q == IDX_RDP_HI));

  sram_cmd_ptr #(.ADDR_W(ADDR_W), .WRAP_EN(1'b1), .WRAP_BASE(RX_BASE[ADDR_W-1:0])) u_rd_ptr (
    .clk(clk), .rst(rst),
    .ld_lo(reg_wr && idx_q == IDX_RDP_LO), .ld_hi(reg_wr && idx_q == IDX_RDP_HI),
    .din(hst_wdata[7:0]), .adv(rd_adv), .step2(bus16), .preset(rx_preset), .q(rd_ptr));

  sram_cmd_ptr #(.ADDR_W(ADDR_W), .WRAP_EN(1'b0), .WRAP_BASE('0)) u_wr_ptr (
    .clk(clk), .rst(rst),
    .ld_lo(reg_wr && idx_q == IDX_WRP_LO), .ld_hi(reg_wr && idx_q == IDX_WRP_HI),
    .din(hst_wdata[7:0]), .adv(wr_adv), .step2(bus16), .preset(1'b0), .q(wr_ptr));

  sram_cmd_pfbuf #(.TAG_W(WA_W), .DW(16)) u_pfbuf (
    .clk(clk), .rst(rst),
    .load(pf_load), .load_tag(pend_addr[ADDR_W-1:1]), .load_data(sram_rdata),
    .inval(pf_inval), .snoop_en(wr_acc), .snoop_tag(wr_ptr[ADDR_W-1:1]),
    .look_tag(rd_ptr[ADDR_W-1:1]), .hit(pf_hit), .data(pf_data));

  always_comb begin
    case (idx_q)
      IDX_RDP_LO: reg_byte = rd_ptr[7:0];
      IDX_RDP_HI: reg_byte = 8'(rd_ptr[ADDR_W-1:8]);
      IDX_WRP_LO: reg_byte = wr_ptr[7:0];
      IDX_WRP_HI: reg_byte = 8'(wr_ptr[ADDR_W-1:8]);
      IDX_TXL_LO: reg_byte = txlen_q[7:0];
      IDX_TXL_HI: reg_byte = txlen_q[15:8];
      default:    reg_byte = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      idx_q      <= '0;
      pend_idx   <= '0;
      pend_addr  <= '0;
      txlen_q    <= '0;
      hst_ack    <= 1'b0;
      hst_rdata  <= '0;
      sram_re    <= 1'b0;
      sram_we    <= 1'b0;
      sram_be    <= '0;
      sram_addr  <= '0;
      sram_wdata <= '0;
    end else begin
      hst_ack <= 1'b0;
      sram_re <= 1'b0;
      sram_we <= 1'b0;
      case (state)
        ST_IDLE: if (go) begin
          if (hst_index) begin
            if (hst_write) idx_q <= hst_wdata[7:0];
            hst_rdata <= {8'h00, idx_q};
            hst_ack   <= 1'b1;
          end else if (rd_hit) begin
            hst_rdata <= lane_pick(pf_data, bus16, rd_ptr[0]);
            hst_ack   <= 1'b1;
          end else if (rd_miss) begin
            sram_re   <= 1'b1;
            sram_addr <= rd_ptr[ADDR_W-1:1];
            pend_idx  <= idx_q;
            pend_addr <= rd_ptr;
            state     <= ST_FETCH;
          end else if (wr_acc) begin
            sram_we    <= 1'b1;
            sram_addr  <= wr_ptr[ADDR_W-1:1];
            sram_be    <= bus16 ? 2'b11 : (wr_ptr[0] ? 2'b10 : 2'b01);
            sram_wdata <= bus16 ? hst_wdata : {hst_wdata[7:0], hst_wdata[7:0]};
            hst_ack    <= 1'b1;
          end else if (hst_write) begin
            if (idx_q == IDX_TXL_LO) txlen_q[7:0]  <= hst_wdata[7:0];
            if (idx_q == IDX_TXL_HI) txlen_q[15:8] <= hst_wdata[7:0];
            hst_ack <= 1'b1;
          end else begin
            hst_rdata <= {8'h00, reg_byte};
            hst_ack   <= 1'b1;
          end
        end
        ST_FETCH: state <= ST_LAND;
        default: begin
          hst_rdata <= lane_pick(sram_rdata, bus16, pend_addr[0]);
          hst_ack   <= 1'b1;
          state     <= ST_IDLE;
        end
      endcase
    end
  end

  assert_fetch_strobe_R2: assert property (@(posedge clk) disable iff (rst)
    sram_re |=> !sram_re);

  assert_miss_ack_R2: assert property (@(posedge clk) disable iff (rst)
    sram_re |-> ##2 hst_ack);

  assert_write_lanes_R7: assert property (@(posedge clk) disable iff (rst)
    sram_we |-> (sram_be != 2'b00));
endmodule

// File: tb/sram_cmd_port_test.sv
module sram_cmd_port_test;
  localparam int AW = 14;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus16 = 1'b0;
  logic rx_preset = 1'b0;
  logic hst_req = 1'b0;
  logic hst_index = 1'b0;
  logic hst_write = 1'b0;
  logic [15:0] hst_wdata = '0;
  logic hst_ack;
  logic [15:0] hst_rdata;
  logic sram_re, sram_we;
  logic [1:0] sram_be;
  logic [AW-2:0] sram_addr;
  logic [15:0] sram_wdata;
  logic [15:0] sram_rdata = '0;

  int checks = 0;
  int fails = 0;

  int rp = 0, wp = 0, txl = 0, pft = 0;
  bit pfv = 1'b0;

  logic [15:0] sram_mem [int];
  logic [15:0] ref_mem [int];

  always #4 clk = ~clk;

  sram_cmd_port uut (
    .clk(clk), .rst(rst), .bus16(bus16), .rx_preset(rx_preset),
    .hst_req(hst_req), .hst_index(hst_index), .hst_write(hst_write),
    .hst_wdata(hst_wdata), .hst_ack(hst_ack), .hst_rdata(hst_rdata),
    .sram_re(sram_re), .sram_we(sram_we), .sram_be(sram_be),
    .sram_addr(sram_addr), .sram_wdata(sram_wdata), .sram_rdata(sram_rdata));

  function automatic logic [15:0] init_word(int a);
    logic [15:0] x;
    x = 16'(a);
    return (x * 16'h9E37) ^ 16'h5A3C;
  endfunction

  function automatic logic [15:0] ref_word(int a);
    return ref_mem.exists(a) ? ref_mem[a] : init_word(a);
  endfunction

  always @(posedge clk) begin
    if (sram_re)
      sram_rdata <= sram_mem.exists(int'(sram_addr)) ? sram_mem[int'(sram_addr)]
                                                      : init_word(int'(sram_addr));
    if (sram_we) begin
      logic [15:0] w;
      w = sram_mem.exists(int'(sram_addr)) ? sram_mem[int'(sram_addr)] : init_word(int'(sram_addr));
      if (sram_be[0]) w[7:0] = sram_wdata[7:0];
      if (sram_be[1]) w[15:8] = sram_wdata[15:8];
      sram_mem[int'(sram_addr)] = w;
    end
  end

  task automatic chk(string req, string what, int got, int exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic acc(bit idx, bit wr, int d, output logic [15:0] rd, output int lat);
    @(negedge clk);
    hst_req = 1'b1; hst_index = idx; hst_write = wr; hst_wdata = 16'(d);
    @(negedge clk);
    hst_req = 1'b0;
    lat = 1;
    while (!hst_ack && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    rd = hst_rdata;
  endtask

  task automatic sel(int i);
    logic [15:0] r; int l;
    acc(1'b1, 1'b1, i, r, l);
  endtask

  task automatic wreg(int i, int v);
    logic [15:0] r; int l;
    sel(i);
    acc(1'b0, 1'b1, v, r, l);
    case (i)
      'hF4: begin rp = (rp & 'h3F00) | (v & 'hFF); pfv = 1'b0; end
      'hF5: begin rp = (rp & 'hFF) | ((v & 'h3F) << 8); pfv = 1'b0; end
      'hFA: wp = (wp & 'h3F00) | (v & 'hFF);
      'hFB: wp = (wp & 'hFF) | ((v & 'h3F) << 8);
      'hFC: txl = (txl & 'hFF00) | (v & 'hFF);
      'hFD: txl = (txl & 'hFF) | ((v & 'hFF) << 8);
      default: ;
    endcase
  endtask

  task automatic rreg(int i, int exp, string req);
    logic [15:0] r; int l;
    sel(i);
    acc(1'b0, 1'b0, 0, r, l);
    chk(req, $sformatf("register %h", i), int'(r), exp);
  endtask

  task automatic set_rp(int v);
    wreg('hF4, v & 'hFF);
    wreg('hF5, v >> 8);
  endtask

  task automatic set_wp(int v);
    wreg('hFA, v & 'hFF);
    wreg('hFB, v >> 8);
  endtask

  // One data cycle of a read command; the index must already be selected.
  task automatic rd_data(int cmd, string req);
    logic [15:0] w, r; int l, explat, exp; bit hit;
    w = ref_word(rp >> 1);
    exp = bus16 ? int'(w) : ((rp & 1) ? int'(w[15:8]) : int'(w[7:0]));
    hit = pfv && (pft == (rp >> 1));
    explat = hit ? 1 : 3;
    if (cmd == 'hF0 && !hit) begin pfv = 1'b1; pft = rp >> 1; end
    if (cmd == 'hF2) begin
      rp = rp + (bus16 ? 2 : 1);
      if (rp > 'h3FFF) rp = 'h0C00;
    end
    acc(1'b0, 1'b0, 0, r, l);
    chk(req, $sformatf("read %h data", cmd), int'(r), exp);
    chk(req, $sformatf("read %h latency", cmd), l, explat);
  endtask

  // One data cycle of a write command; the index must already be selected.
  task automatic wr_data(int cmd, int v, string req);
    logic [15:0] w, r; int a, l;
    a = wp >> 1;
    w = ref_word(a);
    if (bus16) w = 16'(v);
    else if (wp & 1) w[15:8] = 8'(v);
    else w[7:0] = 8'(v);
    ref_mem[a] = w;
    if (pfv && pft == a) pfv = 1'b0;
    if (cmd == 'hF8) wp = (wp + (bus16 ? 2 : 1)) & 'h3FFF;
    acc(1'b0, 1'b1, v, r, l);
    chk(req, $sformatf("write %h latency", cmd), l, 1);
  endtask

  task automatic pulse_preset();
    @(negedge clk); rx_preset = 1'b1;
    @(negedge clk); rx_preset = 1'b0;
    rp = (rp & 'hFF) | 'h0C00;
    pfv = 1'b0;
  endtask

  initial begin
    #(8 * 100000);
    fails++;
    checks++;
    $display("FAIL R1 watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R1", "ack during reset", int'(hst_ack), 0);
    rst = 1'b0;
    @(negedge clk);

    // R1 R8: reset values
    rreg('hF4, 0, "R1"); rreg('hF5, 0, "R1");
    rreg('hFA, 0, "R1"); rreg('hFB, 0, "R1");
    rreg('hFC, 0, "R8"); rreg('hFD, 0, "R8");

    // R8: register read/write, unused high bits
    wreg('hFC, 'h34); wreg('hFD, 'hA2);
    rreg('hFC, 'h34, "R8"); rreg('hFD, 'hA2, "R8");
    wreg('hF5, 'hFF);
    rreg('hF5, 'h3F, "R8");
    set_rp('h0C10);
    rreg('hF4, 'h10, "R8"); rreg('hF5, 'h0C, "R8");

    // R2 R4: F1 reads leave pointer, never load buffer
    sel('hF1);
    rd_data('hF1, "R2"); rd_data('hF1, "R4");
    rreg('hF4, 'h10, "R2");

    // R1 R3: repeated F2 data cycles with one index write
    sel('hF2);
    rd_data('hF2, "R3"); rd_data('hF2, "R1"); rd_data('hF2, "R3");
    rreg('hF4, 'h13, "R3");

    // R4: prefetch then hits, F2 hit advances
    sel('hF0);
    rd_data('hF0, "R4"); rd_data('hF0, "R4");
    sel('hF2); rd_data('hF2, "R4");
    sel('hF1); rd_data('hF1, "R4");

    // R5: rewriting a pointer byte with the same value empties the buffer
    sel('hF0); rd_data('hF0, "R5");
    wreg('hF4, rp & 'hFF);
    sel('hF1); rd_data('hF1, "R5");

    // R6: wrap in 16-bit and 8-bit modes
    @(negedge clk); bus16 = 1'b1;
    set_rp('h3FFE);
    sel('hF2); rd_data('hF2, "R6");
    rreg('hF5, 'h0C, "R6"); rreg('hF4, 'h00, "R6");
    @(negedge clk); bus16 = 1'b0;
    set_rp('h3FFF);
    sel('hF2); rd_data('hF2, "R6");
    rreg('hF5, 'h0C, "R6"); rreg('hF4, 'h00, "R6");

    // R7: writes in 8-bit mode
    set_wp('h0020);
    sel('hF6); wr_data('hF6, 'hAB, "R7");
    rreg('hFA, 'h20, "R7");
    sel('hF8); wr_data('hF8, 'h11, "R7"); wr_data('hF8, 'h22, "R7");
    rreg('hFA, 'h22, "R7");
    set_rp('h0020);
    sel('hF2); rd_data('hF2, "R7"); rd_data('hF2, "R7");

    // R7: 16-bit little-endian write with odd pointer
    @(negedge clk); bus16 = 1'b1;
    set_wp('h0031);
    sel('hF8); wr_data('hF8, 'hBEEF, "R7");
    rreg('hFA, 'h33, "R7");
    set_rp('h0030);
    sel('hF1); rd_data('hF1, "R7");
    @(negedge clk); bus16 = 1'b0;
    set_rp('h0031);
    sel('hF1); rd_data('hF1, "R7");

    // R10: writing the buffered word empties the buffer
    set_rp('h0040);
    sel('hF0); rd_data('hF0, "R10");
    set_wp('h0041);
    sel('hF6); wr_data('hF6, 'h77, "R10");
    sel('hF1); rd_data('hF1, "R10");

    // R9: preset forces high byte, keeps low byte, empties buffer
    set_rp('h3F25);
    pulse_preset();
    rreg('hF5, 'h0C, "R9"); rreg('hF4, 'h25, "R9");
    sel('hF0); rd_data('hF0, "R9");
    pulse_preset();
    sel('hF1); rd_data('hF1, "R9");

    // R11: writes to non-writable indices are ignored; unknown index reads zero
    wreg('h33, 'h5A);
    rreg('h33, 0, "R11");
    wreg('hF0, 'h99);
    rreg('hF4, rp & 'hFF, "R11"); rreg('hF5, rp >> 8, "R11");
    rreg('hF6, 0, "R11");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule